// File: doc/BRIEF.md
# PCI Target Data Path

This block is the data path of a PCI target. It sits between the multiplexed address/data bus and a plain user port. The inbound half of the bus is registered on every clock. During a write data phase, the registered word and its byte enables are shown to the user side, together with an active-low strobe that marks the single clock in which an external FIFO must take them. During a read, the user's data goes through a registered output stage onto the bus. That stage freezes while the initiator holds off with wait states.

The block also registers two steering lines for the user side. One sets the direction of the user data bus and turns off the user's read drivers whenever the target is not reading. The other chooses between an external configuration-space device and the user device. A separate control machine supplies the phase, direction, ready and select inputs. Parity and the FIFO storage are handled outside this block.

Top module: `pci_tgt_datapath`

## Requirements
- R1: `usr_wdata` and `usr_wbe_n` show the values `ad_in` and `cbe_n_in` had at the previous rising clock edge. This holds on every clock, whatever the phase and ready inputs are.
- R2: A write transfer is sampled at an edge where `data_phase`=1, `is_write`=1, `irdy_n`=0 and `trdy_n`=0. After that edge, `fifo_wr_n` is 0 for exactly one clock, and during that clock `usr_wdata`/`usr_wbe_n` carry the word and byte enables sampled at the edge.
- R3: `fifo_wr_n` is 1 during reset and after any edge that did not sample a write transfer. This includes read phases and edges where either ready input is 1.
- R4: After an edge that samples a read data phase (`data_phase`=1, `is_write`=0) with `irdy_n`=1, `ad_out` keeps its previous value.
- R5: After an edge that samples `irdy_n`=0, or that samples no read data phase, `ad_out` equals the value `usr_rdata` had at that edge.
- R6: `ad_oe` is 1 only after an edge that sampled a read data phase with `devsel_n`=0. It is 0 during reset and at all other times.
- R7: `usr_dir_wr` is 0 only after an edge that sampled a read data phase. It is 1 during reset and at all other times, which disables the user read drivers.
- R8: `cfg_mode` equals `cfg_sel` as sampled at the previous edge: 1 steers to the configuration device, 0 to the user device. It is 0 during reset.
- R9: During reset, `ad_out`, `usr_wdata` and `usr_wbe_n` read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ad_in | input | DW | Inbound address/data bus |
| cbe_n_in | input | DW/8 | Inbound command/byte-enable bus, active low |
| data_phase | input | 1 | Control machine is in a data transfer phase |
| is_write | input | 1 | Current transaction writes to the target |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready from control, active low |
| devsel_n | input | 1 | Device select from control, active low |
| cfg_sel | input | 1 | Transaction addresses configuration space |
| usr_rdata | input | DW | Read data from the user device |
| ad_out | output | DW | Registered outbound data |
| ad_oe | output | 1 | Output enable for `ad_out` |
| usr_wdata | output | DW | Write data to the user side |
| usr_wbe_n | output | DW/8 | Write byte enables, active low |
| fifo_wr_n | output | 1 | FIFO write strobe, active low |
| usr_dir_wr | output | 1 | User bus direction: 1 write, 0 read |
| cfg_mode | output | 1 | 1 configuration device, 0 user device |

## Verification
The assertions assume that the control inputs never mark a phase as both read and write. They also assume that `devsel_n` is only asserted while the control machine owns the transaction. The stimulus sets `is_write` once per transaction, before `data_phase` rises, and never changes it mid-phase. The stimulus moves inputs one time unit after each rising edge, so every sampled value has been stable for most of a cycle.

// File: rtl/pci_tgt_datapath.sv
module pci_tgt_datapath #(
  parameter int DW  = 32,
  parameter int BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  ad_in,
  input  logic [BEW-1:0] cbe_n_in,
  input  logic           data_phase,
  input  logic           is_write,
  input  logic           irdy_n,
  input  logic           trdy_n,
  input  logic           devsel_n,
  input  logic           cfg_sel,
  input  logic [DW-1:0]  usr_rdata,
  output logic [DW-1:0]  ad_out,
  output logic           ad_oe,
  output logic [DW-1:0]  usr_wdata,
  output logic [BEW-1:0] usr_wbe_n,
  output logic           fifo_wr_n,
  output logic           usr_dir_wr,
  output logic           cfg_mode
);

  logic [DW-1:0]  ad_q;
  logic [BEW-1:0] be_q;
  logic [DW-1:0]  out_q;
  logic           strobe_n_q, oe_q, dir_q, mode_q;

  wire rd_phase = data_phase & ~is_write;
  wire wr_xfer  = data_phase & is_write & ~irdy_n & ~trdy_n;
  wire rd_stall = rd_phase & irdy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_q <= '0;
      be_q <= '0;
    end else begin
      ad_q <= ad_in;
      be_q <= cbe_n_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_q <= '0;
    else if (!rd_stall) out_q <= usr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_n_q <= 1'b1;
      oe_q       <= 1'b0;
      dir_q      <= 1'b1;
      mode_q     <= 1'b0;
    end else begin
      strobe_n_q <= ~wr_xfer;
      oe_q       <= rd_phase & ~devsel_n;
      dir_q      <= ~rd_phase;
      mode_q     <= cfg_sel;
    end
  end

  assign usr_wdata  = ad_q;
  assign usr_wbe_n  = be_q;
  assign ad_out     = out_q;
  assign ad_oe      = oe_q;
  assign fifo_wr_n  = strobe_n_q;
  assign usr_dir_wr = dir_q;
  assign cfg_mode   = mode_q;

  a_r2_strobe_means_write_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_wr_n |-> usr_dir_wr);

  a_r3_no_strobe_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_wr_n |-> !ad_oe);

  a_r4_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phase && irdy_n) |=> $stable(ad_out));

  a_r5_advance_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phase && !irdy_n) |=> (ad_out == $past(usr_rdata)));

  a_r6_oe_only_reading: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !usr_dir_wr);

  a_r2_single_clock_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_wr_n && !data_phase) |=> fifo_wr_n);

endmodule

// File: tb/test_pci_tgt_datapath.sv
module test_pci_tgt_datapath;
  localparam int DW = 32;
  localparam int BEW = DW / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] ad_in = '0, usr_rdata = '0;
  logic [BEW-1:0] cbe_n_in = '1;
  logic data_phase = 1'b0, is_write = 1'b0, irdy_n = 1'b1, trdy_n = 1'b1;
  logic devsel_n = 1'b1, cfg_sel = 1'b0;
  logic [DW-1:0] ad_out, usr_wdata;
  logic [BEW-1:0] usr_wbe_n;
  logic ad_oe, fifo_wr_n, usr_dir_wr, cfg_mode;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pci_tgt_datapath #(.DW(DW)) i_pci_tgt_datapath (
    .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_n_in(cbe_n_in),
    .data_phase(data_phase), .is_write(is_write), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .devsel_n(devsel_n), .cfg_sel(cfg_sel),
    .usr_rdata(usr_rdata), .ad_out(ad_out), .ad_oe(ad_oe),
    .usr_wdata(usr_wdata), .usr_wbe_n(usr_wbe_n), .fifo_wr_n(fifo_wr_n),
    .usr_dir_wr(usr_dir_wr), .cfg_mode(cfg_mode));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    ad_in = 32'hdead_beef; usr_rdata = 32'h1234_5678; cfg_sel = 1'b1;
    data_phase = 1'b1; is_write = 1'b1; irdy_n = 1'b0; trdy_n = 1'b0;
    tick(); tick();
    chk("R9 ad_out", ad_out, '0);
    chk("R9 usr_wdata", usr_wdata, '0);
    chk("R3 fifo_wr_n in reset", {31'b0, fifo_wr_n}, 1);
    chk("R6 ad_oe in reset", {31'b0, ad_oe}, 0);
    chk("R7 dir in reset", {31'b0, usr_dir_wr}, 1);
    chk("R8 cfg_mode in reset", {31'b0, cfg_mode}, 0);
    data_phase = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1; cfg_sel = 1'b0;
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_capture();
    for (int i = 0; i < 4; i++) begin
      ad_in = 32'h0101_0101 * (i + 3);
      cbe_n_in = 4'(i + 6);
      tick();
      chk("R1 capture data", usr_wdata, 32'h0101_0101 * (i + 3));
      chk("R1 capture be", {28'b0, usr_wbe_n}, {28'b0, 4'(i + 6)});
      chk("R3 idle no strobe", {31'b0, fifo_wr_n}, 1);
    end
  endtask

  task automatic t_write_burst();
    is_write = 1'b1; data_phase = 1'b1; irdy_n = 1'b0; trdy_n = 1'b0;
    ad_in = 32'haaaa_0001; cbe_n_in = 4'h0;
    tick();
    chk("R2 strobe 1", {31'b0, fifo_wr_n}, 0);
    chk("R2 data 1", usr_wdata, 32'haaaa_0001);
    chk("R7 dir write", {31'b0, usr_dir_wr}, 1);
    irdy_n = 1'b1; ad_in = 32'haaaa_0002;
    tick();
    chk("R3 wait no strobe", {31'b0, fifo_wr_n}, 1);
    irdy_n = 1'b0; trdy_n = 1'b1; ad_in = 32'haaaa_0003;
    tick();
    chk("R3 trdy high no strobe", {31'b0, fifo_wr_n}, 1);
    trdy_n = 1'b0; ad_in = 32'haaaa_0004; cbe_n_in = 4'h5;
    tick();
    chk("R2 strobe 2", {31'b0, fifo_wr_n}, 0);
    chk("R2 data 2", usr_wdata, 32'haaaa_0004);
    chk("R2 be 2", {28'b0, usr_wbe_n}, 32'h5);
    data_phase = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1;
    tick();
    chk("R2 strobe one clock", {31'b0, fifo_wr_n}, 1);
  endtask

  task automatic t_read_stall();
    is_write = 1'b0; data_phase = 1'b1; devsel_n = 1'b0; irdy_n = 1'b0;
    usr_rdata = 32'hbbbb_0001;
    tick();
    chk("R5 read first", ad_out, 32'hbbbb_0001);
    chk("R6 oe on read", {31'b0, ad_oe}, 1);
    chk("R7 dir read", {31'b0, usr_dir_wr}, 0);
    chk("R3 no strobe on read", {31'b0, fifo_wr_n}, 1);
    irdy_n = 1'b1; usr_rdata = 32'hbbbb_0002;
    tick();
    chk("R4 hold 1", ad_out, 32'hbbbb_0001);
    usr_rdata = 32'hbbbb_0003;
    tick();
    chk("R4 hold 2", ad_out, 32'hbbbb_0001);
    irdy_n = 1'b0;
    tick();
    chk("R5 advance", ad_out, 32'hbbbb_0003);
    devsel_n = 1'b1;
    tick();
    chk("R6 oe off without devsel", {31'b0, ad_oe}, 0);
    data_phase = 1'b0; irdy_n = 1'b1; usr_rdata = 32'hbbbb_0004;
    tick();
    chk("R5 idle load", ad_out, 32'hbbbb_0004);
    chk("R6 oe off idle", {31'b0, ad_oe}, 0);
    chk("R7 dir back high", {31'b0, usr_dir_wr}, 1);
  endtask

  task automatic t_cfg();
    cfg_sel = 1'b1;
    tick();
    chk("R8 cfg high", {31'b0, cfg_mode}, 1);
    cfg_sel = 1'b0;
    tick();
    chk("R8 cfg low", {31'b0, cfg_mode}, 0);
  endtask

  initial begin
    t_reset();
    t_capture();
    t_write_burst();
    t_read_stall();
    t_cfg();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule